// File: doc/BRIEF.md
# Flash Descriptor Loader and Validator

This block runs while the rest of the chip is still held in reset. It walks the flash image through a byte-read port that has a valid handshake. First it checks the 32-bit signature at the descriptor base. It then fills read-only shadow registers that a downstream access checker uses: two map words, five region base/limit pairs and three master permission words. When the walk ends it releases reset to the rest of the design and reports whether descriptor mode is active.

Two image layouts are supported, selected by a strap input that is held stable during reset. In the first layout the descriptor starts at flash byte 0. In the second it starts at byte 10h, and the sixteen bytes below it are never read. Every section offset is a flash byte offset from the descriptor base. Each section pointer is an 8-bit map field shifted left by four bits. Contents of the strap and component sections are not interpreted.

Top module: `fdesc_loader`

## Requirements
- R1: While rst_ni is low, the block shows the following. done_o, err_o, desc_mode_o and sys_rst_no are 0. The map words and master words are 0. Every region slot holds the disabled pair: base 1FFFh, limit 0.
- R2: The descriptor base is byte 0 when layout_i=0 and byte 10h when layout_i=1. When layout_i=1, no address below 10h is ever requested.
- R3: If the word at the base equals 0FF0A55Ah, desc_mode_o=1 and err_o=0 once done_o rises.
- R4: On a signature mismatch, only the signature word is read. The block then ends with done_o=1, err_o=1, desc_mode_o=0 and sys_rst_no=1, with all regions disabled and all map and master words 0. err_o holds until reset.
- R5: Each 32-bit word is assembled little-endian: the byte at the lowest address lands in bits 7:0. A byte-reversed signature is therefore a mismatch.
- R6: map0_o is loaded from base+4 and map1_o from base+8.
- R7: The region table starts at base + (map0[23:16] << 4). Entry i sits at table + 4*i. Its base field is bits 12:0 and its limit field is bits 28:16.
- R8: map0[26:24] holds the region count minus one. Slots above that count keep the disabled pair. A count above NUM_REGIONS-1 is clamped to NUM_REGIONS-1.
- R9: The master section starts at base + (map1[7:0] << 4). Three consecutive words are loaded into mstr_o slots 0, 1 and 2, in the order CPU, management engine, network controller.
- R10: sys_rst_no stays low until done_o rises. done_o holds until reset, no read is requested after it rises, and the shadow registers stay unchanged afterwards.
- R11: A byte is consumed only in a cycle where rd_req_o and rd_valid_i are both high. rd_addr_o holds while a request waits. Bytes of a word are requested at consecutive addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| layout_i | input | 1 | Layout strap: 0 puts the base at byte 0, 1 puts it at byte 10h |
| rd_req_o | output | 1 | Byte read request |
| rd_addr_o | output | ADDR_W | Flash byte address |
| rd_valid_i | input | 1 | rd_data_i carries the requested byte |
| rd_data_i | input | 8 | Read byte |
| done_o | output | 1 | Load finished |
| err_o | output | 1 | Sticky signature mismatch |
| desc_mode_o | output | 1 | Descriptor mode active |
| sys_rst_no | output | 1 | Active-low reset released to the rest of the chip |
| map0_o | output | 32 | Map word at base+4 |
| map1_o | output | 32 | Map word at base+8 |
| rgn_base_o | output | 13*NUM_REGIONS | Region base fields, slot i at bits 13i+12:13i |
| rgn_limit_o | output | 13*NUM_REGIONS | Region limit fields, same packing |
| mstr_o | output | 32*NUM_MASTERS | Master permission words, slot j at bits 32j+31:32j |

## Verification
A wrong section pointer or a wrong shift moves every later read. At the ports this shows as wrong shadow contents once done_o rises, and the bench compares those against words it computes from its own image. A miscounted byte index or a skipped handshake changes how many bytes are consumed, which the bench counts directly. A broken region clamp or a failing signature gate shows as a non-disabled slot or a stray desc_mode_o. Every such fault is visible within one load, a few hundred cycles.

// File: rtl/fdesc_pkg.sv
package fdesc_pkg;
  localparam logic [31:0] SIG_WORD   = 32'h0FF0A55A;
  localparam int          FLD_W      = 13;
  localparam logic [12:0] DIS_BASE   = 13'h1FFF;
  localparam logic [12:0] DIS_LIMIT  = 13'h0000;
  localparam int          NEW_BASE   = 16;

  typedef enum logic [2:0] {
    ST_SIG, ST_MAP0, ST_MAP1, ST_RGN, ST_MST, ST_DONE
  } st_e;
endpackage

// File: rtl/fdesc_word_fetch.sv
module fdesc_word_fetch #(
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [7:0]        rd_data_i,
  output logic [31:0]       word_o,
  output logic              word_vld_o
);
  logic              busy_q;
  logic [1:0]        idx_q;
  logic [ADDR_W-1:0] cur_q;
  logic [31:0]       word_q;
  logic              vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      cur_q  <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (!busy_q && start_i) begin
        busy_q <= 1'b1;
        cur_q  <= addr_i;
        idx_q  <= '0;
      end else if (busy_q && rd_valid_i) begin
        // little-endian: lowest address fills the low byte
        word_q[{idx_q, 3'b000} +: 8] <= rd_data_i;
        if (idx_q == 2'd3) begin
          busy_q <= 1'b0;
          vld_q  <= 1'b1;
        end else begin
          idx_q <= idx_q + 2'd1;
          cur_q <= cur_q + ADDR_W'(1);
        end
      end
    end
  end

  assign rd_req_o   = busy_q;
  assign rd_addr_o  = cur_q;
  assign word_o     = word_q;
  assign word_vld_o = vld_q;
endmodule

// File: rtl/fdesc_ctrl.sv
module fdesc_ctrl
  import fdesc_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int NUM_REGIONS = 5,
  parameter int NUM_MASTERS = 3,
  localparam int MAXN  = (NUM_REGIONS > NUM_MASTERS) ? NUM_REGIONS : NUM_MASTERS,
  localparam int IDX_W = $clog2(MAXN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              layout_i,
  input  logic [31:0]       word_i,
  input  logic              word_vld_i,
  output logic              start_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ld_map0_o,
  output logic              ld_map1_o,
  output logic              ld_rgn_o,
  output logic              ld_mst_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              done_o,
  output logic              err_o,
  output logic              mode_o
);
  st_e              st_q;
  logic             issued_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] rgn_last_q;
  logic [7:0]       rgn_ptr_q;
  logic [7:0]       mst_ptr_q;
  logic             err_q;
  logic             mode_q;
  logic [2:0]       cnt;
  logic [ADDR_W-1:0] base;

  assign base = layout_i ? ADDR_W'(NEW_BASE) : '0;
  assign cnt  = word_i[26:24];

  always_comb begin
    unique case (st_q)
      ST_MAP0: addr_o = base + ADDR_W'(4);
      ST_MAP1: addr_o = base + ADDR_W'(8);
      ST_RGN:  addr_o = base + ADDR_W'({rgn_ptr_q, 4'h0}) + ADDR_W'({idx_q, 2'b00});
      ST_MST:  addr_o = base + ADDR_W'({mst_ptr_q, 4'h0}) + ADDR_W'({idx_q, 2'b00});
      default: addr_o = base;
    endcase
  end

  assign start_o   = (st_q != ST_DONE) && !issued_q;
  assign ld_map0_o = word_vld_i && (st_q == ST_MAP0);
  assign ld_map1_o = word_vld_i && (st_q == ST_MAP1);
  assign ld_rgn_o  = word_vld_i && (st_q == ST_RGN);
  assign ld_mst_o  = word_vld_i && (st_q == ST_MST);
  assign idx_o     = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_SIG;
      issued_q   <= 1'b0;
      idx_q      <= '0;
      rgn_last_q <= '0;
      rgn_ptr_q  <= '0;
      mst_ptr_q  <= '0;
      err_q      <= 1'b0;
      mode_q     <= 1'b0;
    end else begin
      if (start_o) issued_q <= 1'b1;
      if (word_vld_i) begin
        issued_q <= 1'b0;
        unique case (st_q)
          ST_SIG: begin
            if (word_i == SIG_WORD) begin
              st_q <= ST_MAP0;
            end else begin
              err_q <= 1'b1;
              st_q  <= ST_DONE;
            end
          end
          ST_MAP0: begin
            rgn_ptr_q  <= word_i[23:16];
            rgn_last_q <= (int'(cnt) > NUM_REGIONS - 1) ? IDX_W'(NUM_REGIONS - 1)
                                                        : IDX_W'(cnt);
            st_q       <= ST_MAP1;
          end
          ST_MAP1: begin
            mst_ptr_q <= word_i[7:0];
            idx_q     <= '0;
            st_q      <= ST_RGN;
          end
          ST_RGN: begin
            if (idx_q == rgn_last_q) begin
              idx_q <= '0;
              st_q  <= ST_MST;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end
          ST_MST: begin
            if (idx_q == IDX_W'(NUM_MASTERS - 1)) begin
              mode_q <= 1'b1;
              st_q   <= ST_DONE;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign done_o = (st_q == ST_DONE);
  assign err_o  = err_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/fdesc_loader.sv
module fdesc_loader
  import fdesc_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int NUM_REGIONS = 5,
  parameter int NUM_MASTERS = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         layout_i,
  output logic                         rd_req_o,
  output logic [ADDR_W-1:0]            rd_addr_o,
  input  logic                         rd_valid_i,
  input  logic [7:0]                   rd_data_i,
  output logic                         done_o,
  output logic                         err_o,
  output logic                         desc_mode_o,
  output logic                         sys_rst_no,
  output logic [31:0]                  map0_o,
  output logic [31:0]                  map1_o,
  output logic [NUM_REGIONS*FLD_W-1:0] rgn_base_o,
  output logic [NUM_REGIONS*FLD_W-1:0] rgn_limit_o,
  output logic [NUM_MASTERS*32-1:0]    mstr_o
);
  localparam int MAXN  = (NUM_REGIONS > NUM_MASTERS) ? NUM_REGIONS : NUM_MASTERS;
  localparam int IDX_W = $clog2(MAXN + 1);

  logic              start;
  logic [ADDR_W-1:0] start_addr;
  logic [31:0]       word;
  logic              word_vld;
  logic              ld_map0, ld_map1, ld_rgn, ld_mst;
  logic [IDX_W-1:0]  idx;

  fdesc_word_fetch #(.ADDR_W(ADDR_W)) i_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .addr_i     (start_addr),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_valid_i (rd_valid_i),
    .rd_data_i  (rd_data_i),
    .word_o     (word),
    .word_vld_o (word_vld)
  );

  fdesc_ctrl #(
    .ADDR_W      (ADDR_W),
    .NUM_REGIONS (NUM_REGIONS),
    .NUM_MASTERS (NUM_MASTERS)
  ) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .layout_i   (layout_i),
    .word_i     (word),
    .word_vld_i (word_vld),
    .start_o    (start),
    .addr_o     (start_addr),
    .ld_map0_o  (ld_map0),
    .ld_map1_o  (ld_map1),
    .ld_rgn_o   (ld_rgn),
    .ld_mst_o   (ld_mst),
    .idx_o      (idx),
    .done_o     (done_o),
    .err_o      (err_o),
    .mode_o     (desc_mode_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map0_o <= '0;
      map1_o <= '0;
    end else begin
      if (ld_map0) map0_o <= word;
      if (ld_map1) map1_o <= word;
    end
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rgn_base_o[g*FLD_W +: FLD_W]  <= DIS_BASE;
        rgn_limit_o[g*FLD_W +: FLD_W] <= DIS_LIMIT;
      end else if (ld_rgn && idx == IDX_W'(g)) begin
        rgn_base_o[g*FLD_W +: FLD_W]  <= word[12:0];
        rgn_limit_o[g*FLD_W +: FLD_W] <= word[28:16];
      end
    end
  end

  for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_mst
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           mstr_o[g*32 +: 32] <= '0;
      else if (ld_mst && idx == IDX_W'(g))   mstr_o[g*32 +: 32] <= word;
    end
  end

  assign sys_rst_no = done_o;
endmodule

// File: rtl/fdesc_loader_chk.sv
module fdesc_loader_chk
  import fdesc_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int NUM_REGIONS = 5,
  parameter int NUM_MASTERS = 3
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         layout_i,
  input logic                         rd_req_o,
  input logic [ADDR_W-1:0]            rd_addr_o,
  input logic                         rd_valid_i,
  input logic                         done_o,
  input logic                         err_o,
  input logic                         desc_mode_o,
  input logic                         sys_rst_no,
  input logic [31:0]                  map0_o,
  input logic [NUM_REGIONS*FLD_W-1:0] rgn_base_o,
  input logic [NUM_MASTERS*32-1:0]    mstr_o
);
  AST_NO_LOW_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (layout_i && rd_req_o) |-> (rd_addr_o >= ADDR_W'(NEW_BASE)));                   // R2
  AST_MODE_NOT_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !desc_mode_o);                                                         // R4
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);                                                                // R4
  AST_ERR_RGN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && done_o) |-> (rgn_base_o == {NUM_REGIONS{DIS_BASE}} && mstr_o == '0 && map0_o == '0)); // R4
  AST_MODE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_mode_o |-> done_o);                                                         // R3
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_o && sys_rst_no));                                              // R10
  AST_NO_READ_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rd_req_o);                                                           // R10
  AST_SHADOW_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ($stable(rgn_base_o) && $stable(mstr_o) && $stable(map0_o)));         // R10
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o)));                 // R11
endmodule

bind fdesc_loader fdesc_loader_chk #(
  .ADDR_W      (ADDR_W),
  .NUM_REGIONS (NUM_REGIONS),
  .NUM_MASTERS (NUM_MASTERS)
) i_fdesc_loader_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .layout_i    (layout_i),
  .rd_req_o    (rd_req_o),
  .rd_addr_o   (rd_addr_o),
  .rd_valid_i  (rd_valid_i),
  .done_o      (done_o),
  .err_o       (err_o),
  .desc_mode_o (desc_mode_o),
  .sys_rst_no  (sys_rst_no),
  .map0_o      (map0_o),
  .rgn_base_o  (rgn_base_o),
  .mstr_o      (mstr_o)
);

// File: tb/test_fdesc_loader.sv
module test_fdesc_loader;
  localparam int ADDR_W = 24;
  localparam int NR     = 5;
  localparam int NM     = 3;
  localparam int MEM_N  = 4096;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              layout_i = 1'b0;
  logic              rd_req_o;
  logic [ADDR_W-1:0] rd_addr_o;
  logic              rd_valid_i = 1'b0;
  logic [7:0]        rd_data_i = '0;
  logic              done_o, err_o, desc_mode_o, sys_rst_no;
  logic [31:0]       map0_o, map1_o;
  logic [NR*13-1:0]  rgn_base_o, rgn_limit_o;
  logic [NM*32-1:0]  mstr_o;

  logic [7:0] mem [MEM_N];
  int checks = 0;
  int fails  = 0;
  int bytes_served = 0;
  bit low_read = 1'b0;

  always #10 clk_i = ~clk_i;

  fdesc_loader #(.ADDR_W(ADDR_W), .NUM_REGIONS(NR), .NUM_MASTERS(NM)) i_fdesc_loader (
    .clk_i, .rst_ni, .layout_i, .rd_req_o, .rd_addr_o, .rd_valid_i, .rd_data_i,
    .done_o, .err_o, .desc_mode_o, .sys_rst_no, .map0_o, .map1_o,
    .rgn_base_o, .rgn_limit_o, .mstr_o
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd32(input int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  task automatic wr32(input int a, input logic [31:0] w);
    for (int k = 0; k < 4; k++) mem[a+k] = w[8*k +: 8];
  endtask

  // flash responder: random latency, serves the byte at the current address
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && rd_req_o && ($urandom % 4 != 0)) begin
        rd_valid_i = 1'b1;
        rd_data_i  = mem[rd_addr_o[11:0]];
        bytes_served++;
        if (layout_i && rd_addr_o < 16) low_read = 1'b1;
      end else begin
        rd_valid_i = 1'b0;
        rd_data_i  = $urandom;
      end
    end
  end

  // sig_mode: 0 valid, 1 corrupted byte, 2 byte-reversed
  task automatic run_case(input bit lay, input int sig_mode, input logic [2:0] cnt,
                          input logic [7:0] rptr, input logic [7:0] mptr);
    int base, nreg, used, timeout, served_at_done;
    bit ok, rst_early;
    logic [31:0] m0, m1, e;
    rst_ni = 1'b0;
    layout_i = lay;
    for (int a = 0; a < MEM_N; a++) mem[a] = $urandom;
    base = lay ? 16 : 0;
    if (lay) wr32(0, 32'h0FF0A55A);
    case (sig_mode)
      0: wr32(base, 32'h0FF0A55A);
      1: wr32(base, 32'h0FF0A55A ^ (32'h1 << ($urandom % 32)));
      default: wr32(base, 32'h5AA5F00F);
    endcase
    m0 = {5'($urandom), cnt, rptr, 16'($urandom)};
    m1 = {24'($urandom), mptr};
    wr32(base + 4, m0);
    wr32(base + 8, m1);
    ok = (sig_mode == 0);
    repeat (2) @(negedge clk_i);
    // R1 reset state
    chk(!done_o && !err_o && !desc_mode_o && !sys_rst_no && !rd_req_o, "R1 ctl",
        {done_o, err_o, desc_mode_o, sys_rst_no}, 0);
    chk(rgn_base_o == {NR{13'h1FFF}} && rgn_limit_o == '0, "R1 regions", rgn_base_o, 0);
    chk(mstr_o == '0 && map0_o == '0 && map1_o == '0, "R1 masters/maps", mstr_o, 0);
    bytes_served = 0;
    low_read = 1'b0;
    rst_early = 1'b0;
    rst_ni = 1'b1;
    timeout = 0;
    while (!done_o && timeout < 5000) begin
      @(negedge clk_i);
      if (!done_o && sys_rst_no) rst_early = 1'b1;
      timeout++;
    end
    chk(timeout < 5000, "R10 watchdog", timeout, 5000);
    chk(!rst_early, "R10 reset held while loading", rst_early, 0);
    served_at_done = bytes_served;
    repeat (4) @(negedge clk_i);
    chk(done_o && sys_rst_no && !rd_req_o && bytes_served == served_at_done, "R10 done state",
        {done_o, sys_rst_no, rd_req_o}, 3'b110);
    chk(!low_read, "R2 no read below base", low_read, 0);
    chk(desc_mode_o == ok, "R3 mode", desc_mode_o, ok);
    chk(err_o == !ok, "R4 err", err_o, !ok);
    nreg = (int'(cnt) > NR - 1) ? NR : int'(cnt) + 1;
    used = ok ? (3 + nreg + NM) * 4 : 4;
    chk(bytes_served == used, "R11 bytes consumed", bytes_served, used);
    chk(map0_o == (ok ? m0 : 32'h0), "R6 map0", map0_o, ok ? m0 : 32'h0);
    chk(map1_o == (ok ? m1 : 32'h0), "R6 map1", map1_o, ok ? m1 : 32'h0);
    for (int i = 0; i < NR; i++) begin
      logic [12:0] eb, el;
      e  = rd32(base + int'(rptr) * 16 + 4 * i);
      eb = (ok && i < nreg) ? e[12:0]  : 13'h1FFF;
      el = (ok && i < nreg) ? e[28:16] : 13'h0;
      chk(rgn_base_o[i*13 +: 13] == eb && rgn_limit_o[i*13 +: 13] == el,
          (ok && i < nreg) ? "R7 region entry" : "R8 region disabled",
          {rgn_base_o[i*13 +: 13], rgn_limit_o[i*13 +: 13]}, {eb, el});
    end
    for (int j = 0; j < NM; j++) begin
      e = ok ? rd32(base + int'(mptr) * 16 + 4 * j) : 32'h0;
      chk(mstr_o[j*32 +: 32] == e, "R9 master word", mstr_o[j*32 +: 32], e);
    end
  endtask

  initial begin
    void'($urandom(32'd7341));
    run_case(1'b0, 0, 3'd3, 8'h04, 8'h06);   // R7 four regions, old layout
    run_case(1'b1, 0, 3'd3, 8'h04, 8'h06);   // R2 new layout
    run_case(1'b0, 0, 3'd0, 8'h05, 8'h10);   // R8 single region
    run_case(1'b1, 0, 3'd7, 8'h06, 8'h12);   // R8 clamp
    run_case(1'b0, 0, 3'd4, 8'h07, 8'h11);   // R8 exactly full
    run_case(1'b0, 1, 3'd3, 8'h04, 8'h06);   // R4 corrupted
    run_case(1'b1, 1, 3'd3, 8'h04, 8'h06);   // R2 R4 valid word only in reserved bytes
    run_case(1'b0, 2, 3'd2, 8'h04, 8'h06);   // R5 byte-reversed
    for (int n = 0; n < 6; n++)
      run_case(1'($urandom), ($urandom % 5 == 0) ? 1 : 0, 3'($urandom),
               8'h04 + 8'($urandom % 4), 8'h10 + 8'($urandom % 8));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule